// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block translates request addresses for a PCIe-style root port or endpoint. It keeps two banks of translation regions, one for outbound traffic and one for inbound traffic. Each region has an enable, a transaction kind, a base, a last-byte limit and a target. Software reaches every region through one shared group of window registers. A selector register at offset 0x900 picks the bank and the region that the window reads and writes.

Lookups run on a valid/ready stream. A request carries a direction flag, an address and a BAR number. One cycle after acceptance the response holds a hit flag, the translated address and the transaction kind of the winning region. The response output is one register deep. A request is accepted only when that register is empty or is being drained in the same cycle. A response stays on the outputs until `rsp_ready` is seen high. The register port is a plain 32-bit write strobe plus a combinational read. Every register offset must be word aligned.

Top module: `xlat_window_unit`

## Requirements
- R1: After reset every region reads back as all zero and is disabled. The selector reads 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The selector register is at offset 0x900. Bit 31 picks the bank (1 = inbound, 0 = outbound) and bits 3:0 hold the region index. It reads back only those bits; all other bits read 0.
- R3: The window registers are at these offsets: 0x904 kind, 0x908 control, 0x90C base[31:0], 0x910 base[63:32], 0x914 limit, 0x918 target[31:0] and 0x91C target[63:32]. They read and write only the region that the selector names. No other region changes.
- R4: If the selector names an index that its bank does not have, window writes change nothing and window reads return 0.
- R5: The kind register keeps bits 2:0, with codes 0 = memory, 2 = I/O, 4 = configuration type 0 and 5 = configuration type 1. The control register keeps bit 31 (enable), bit 30 (BAR mode) and bits 10:8 (BAR number). Bits that are not kept read 0.
- R6: An enabled outbound region hits when three conditions hold: address[63:32] equals base[63:32], address[31:0] ≥ base[31:0], and address[31:0] ≤ limit. Both range ends are inclusive. The output address is target + (address − base), and the output kind is the region's kind. The BAR mode bit has no effect on outbound regions.
- R7: An enabled inbound region in BAR mode hits when the request's BAR number equals its programmed BAR number. The request address is then the offset into the BAR, and the output address is target + address.
- R8: An enabled inbound region with BAR mode clear matches by address range, using the same rule and translation as R6.
- R9: When several regions of the selected bank hit, the one with the lowest index wins.
- R10: On a miss, `rsp_hit` is 0, `rsp_addr` equals the request address and `rsp_kind` is 0. A disabled region never hits.
- R11: A response appears one cycle after its request is accepted. `req_ready` is high exactly when no response is held or `rsp_ready` is high. A held response keeps all of its fields stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_inbound | input | 1 | 1 = search inbound bank, 0 = outbound bank |
| req_addr | input | 64 | Request address (offset into BAR for BAR-mode hits) |
| req_bar | input | 3 | BAR number of an inbound request |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | A region matched |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_kind | output | 3 | Transaction kind of the winning region |

## Verification
The assertions assume that `rsp_ready` may drop at any time. They also assume that the register port is driven only with word-aligned offsets and that nothing is written while a response they watch is being held. Under those conditions, a held response must not move. The stimulus changes every input shortly after a rising edge and never reprograms a region between accepting a request and consuming its response. The back-pressure case holds `rsp_ready` low for several cycles with a second request waiting.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int XL_REG_AW   = 12;
  localparam int XL_BAR_W    = 3;
  localparam int XL_KIND_W   = 3;
  localparam int XL_VP_IDX_W = 4;
  localparam int XL_AW       = 64;
  localparam int XL_HW       = XL_AW / 2;
  localparam int XL_BAR_LSB  = 8;

  localparam logic [XL_REG_AW-1:0] XL_OFS_VIEW    = 12'h900;
  localparam logic [XL_REG_AW-1:0] XL_OFS_KIND    = 12'h904;
  localparam logic [XL_REG_AW-1:0] XL_OFS_CTRL    = 12'h908;
  localparam logic [XL_REG_AW-1:0] XL_OFS_BASE_LO = 12'h90C;
  localparam logic [XL_REG_AW-1:0] XL_OFS_BASE_HI = 12'h910;
  localparam logic [XL_REG_AW-1:0] XL_OFS_LIMIT   = 12'h914;
  localparam logic [XL_REG_AW-1:0] XL_OFS_TGT_LO  = 12'h918;
  localparam logic [XL_REG_AW-1:0] XL_OFS_TGT_HI  = 12'h91C;

  typedef enum logic [XL_KIND_W-1:0] {
    XL_KIND_MEM  = 3'd0,
    XL_KIND_IO   = 3'd2,
    XL_KIND_CFG0 = 3'd4,
    XL_KIND_CFG1 = 3'd5
  } xl_kind_e;

  typedef struct packed {
    logic                 en;
    logic                 bar_mode;
    logic [XL_BAR_W-1:0]  bar;
    logic [XL_KIND_W-1:0] kind;
    logic [XL_AW-1:0]     base;
    logic [XL_HW-1:0]     limit;
    logic [XL_AW-1:0]     target;
  } xl_region_t;

  // Apply one window write to a region image.
  function automatic xl_region_t xl_apply(xl_region_t r, logic [XL_REG_AW-1:0] ofs,
                                          logic [31:0] d);
    xl_region_t n;
    n = r;
    case (ofs)
      XL_OFS_KIND:    n.kind = d[XL_KIND_W-1:0];
      XL_OFS_CTRL: begin
        n.en       = d[31];
        n.bar_mode = d[30];
        n.bar      = d[XL_BAR_LSB +: XL_BAR_W];
      end
      XL_OFS_BASE_LO: n.base[XL_HW-1:0]      = d;
      XL_OFS_BASE_HI: n.base[XL_AW-1:XL_HW]  = d;
      XL_OFS_LIMIT:   n.limit                = d;
      XL_OFS_TGT_LO:  n.target[XL_HW-1:0]    = d;
      XL_OFS_TGT_HI:  n.target[XL_AW-1:XL_HW] = d;
      default: ;
    endcase
    return n;
  endfunction

  // Read one window register of a region image.
  function automatic logic [31:0] xl_readback(xl_region_t r, logic [XL_REG_AW-1:0] ofs);
    logic [31:0] v;
    v = '0;
    case (ofs)
      XL_OFS_KIND:    v[XL_KIND_W-1:0] = r.kind;
      XL_OFS_CTRL: begin
        v[31]                      = r.en;
        v[30]                      = r.bar_mode;
        v[XL_BAR_LSB +: XL_BAR_W]  = r.bar;
      end
      XL_OFS_BASE_LO: v = r.base[XL_HW-1:0];
      XL_OFS_BASE_HI: v = r.base[XL_AW-1:XL_HW];
      XL_OFS_LIMIT:   v = r.limit;
      XL_OFS_TGT_LO:  v = r.target[XL_HW-1:0];
      XL_OFS_TGT_HI:  v = r.target[XL_AW-1:XL_HW];
      default:        v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/xlat_regfile.sv
module xlat_regfile
  import xlat_pkg::*;
#(
  parameter int NUM_OB = 4,
  parameter int NUM_IB = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [XL_REG_AW-1:0] reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output xl_region_t           ob_regions [NUM_OB],
  output xl_region_t           ib_regions [NUM_IB]
);

  localparam logic [XL_VP_IDX_W:0] OB_CNT = (XL_VP_IDX_W+1)'(NUM_OB);
  localparam logic [XL_VP_IDX_W:0] IB_CNT = (XL_VP_IDX_W+1)'(NUM_IB);

  logic                   vp_dir_q;
  logic [XL_VP_IDX_W-1:0] vp_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vp_dir_q <= 1'b0;
      vp_idx_q <= '0;
    end else if (reg_wr && reg_addr == XL_OFS_VIEW) begin
      vp_dir_q <= reg_wdata[31];
      vp_idx_q <= reg_wdata[XL_VP_IDX_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_OB; g++) begin : g_ob
    always_ff @(posedge clk) begin
      if (rst) ob_regions[g] <= '0;
      else if (reg_wr && !vp_dir_q && vp_idx_q == XL_VP_IDX_W'(g))
        ob_regions[g] <= xl_apply(ob_regions[g], reg_addr, reg_wdata);
    end
  end

  for (genvar g = 0; g < NUM_IB; g++) begin : g_ib
    always_ff @(posedge clk) begin
      if (rst) ib_regions[g] <= '0;
      else if (reg_wr && vp_dir_q && vp_idx_q == XL_VP_IDX_W'(g))
        ib_regions[g] <= xl_apply(ib_regions[g], reg_addr, reg_wdata);
    end
  end

  xl_region_t sel;
  logic       sel_ok;

  always_comb begin
    sel    = '0;
    sel_ok = vp_dir_q ? ({1'b0, vp_idx_q} < IB_CNT) : ({1'b0, vp_idx_q} < OB_CNT);
    for (int i = 0; i < NUM_OB; i++)
      if (!vp_dir_q && vp_idx_q == XL_VP_IDX_W'(i)) sel = ob_regions[i];
    for (int i = 0; i < NUM_IB; i++)
      if (vp_dir_q && vp_idx_q == XL_VP_IDX_W'(i)) sel = ib_regions[i];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == XL_OFS_VIEW) begin
      reg_rdata[31]                = vp_dir_q;
      reg_rdata[XL_VP_IDX_W-1:0]   = vp_idx_q;
    end else if (sel_ok) begin
      reg_rdata = xl_readback(sel, reg_addr);
    end
  end

endmodule

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int NUM     = 4,
  parameter bit INBOUND = 1'b0
) (
  input  xl_region_t           regions [NUM],
  input  logic [XL_AW-1:0]     addr,
  input  logic [XL_BAR_W-1:0]  bar,
  output logic                 hit,
  output logic [XL_AW-1:0]     xaddr,
  output logic [XL_KIND_W-1:0] kind
);

  logic [NUM-1:0]   hit_v;
  logic [XL_AW-1:0] xl_v [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_rgn
    logic in_range;
    assign in_range = regions[g].en
                   && addr[XL_AW-1:XL_HW] == regions[g].base[XL_AW-1:XL_HW]
                   && addr[XL_HW-1:0] >= regions[g].base[XL_HW-1:0]
                   && addr[XL_HW-1:0] <= regions[g].limit;
    if (INBOUND) begin : g_in
      logic bar_hit;
      assign bar_hit  = regions[g].en && regions[g].bar == bar;
      assign hit_v[g] = regions[g].bar_mode ? bar_hit : in_range;
      assign xl_v[g]  = regions[g].bar_mode ? regions[g].target + addr
                                            : regions[g].target + (addr - regions[g].base);
    end else begin : g_out
      logic unused_bar_bits;
      assign unused_bar_bits = ^{regions[g].bar_mode, regions[g].bar, bar};
      assign hit_v[g] = in_range;
      assign xl_v[g]  = regions[g].target + (addr - regions[g].base);
    end
  end

  // Lowest index wins: walk down so the smallest hitting index is last.
  always_comb begin
    hit   = 1'b0;
    xaddr = addr;
    kind  = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        hit   = 1'b1;
        xaddr = xl_v[i];
        kind  = regions[i].kind;
      end
    end
  end

endmodule

// File: rtl/xlat_window_unit.sv
module xlat_window_unit
  import xlat_pkg::*;
#(
  parameter int NUM_OB = 4,
  parameter int NUM_IB = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [XL_REG_AW-1:0] reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_inbound,
  input  logic [XL_AW-1:0]     req_addr,
  input  logic [XL_BAR_W-1:0]  req_bar,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_hit,
  output logic [XL_AW-1:0]     rsp_addr,
  output logic [XL_KIND_W-1:0] rsp_kind
);

  xl_region_t ob_regions [NUM_OB];
  xl_region_t ib_regions [NUM_IB];

  xlat_regfile #(.NUM_OB(NUM_OB), .NUM_IB(NUM_IB)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ob_regions (ob_regions),
    .ib_regions (ib_regions)
  );

  logic                 ob_hit, ib_hit;
  logic [XL_AW-1:0]     ob_xaddr, ib_xaddr;
  logic [XL_KIND_W-1:0] ob_kind, ib_kind;

  xlat_match #(.NUM(NUM_OB), .INBOUND(1'b0)) u_ob_match (
    .regions (ob_regions),
    .addr    (req_addr),
    .bar     (req_bar),
    .hit     (ob_hit),
    .xaddr   (ob_xaddr),
    .kind    (ob_kind)
  );

  xlat_match #(.NUM(NUM_IB), .INBOUND(1'b1)) u_ib_match (
    .regions (ib_regions),
    .addr    (req_addr),
    .bar     (req_bar),
    .hit     (ib_hit),
    .xaddr   (ib_xaddr),
    .kind    (ib_kind)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
      rsp_kind  <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit  <= req_inbound ? ib_hit   : ob_hit;
        rsp_addr <= req_inbound ? ib_xaddr : ob_xaddr;
        rsp_kind <= req_inbound ? ib_kind  : ob_kind;
      end
    end
  end

endmodule

// File: rtl/xlat_window_unit_chk.sv
module xlat_window_unit_chk
  import xlat_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [XL_REG_AW-1:0] reg_addr,
  input logic [31:0]          reg_rdata,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic                 rsp_hit,
  input logic [XL_AW-1:0]     rsp_addr,
  input logic [XL_KIND_W-1:0] rsp_kind
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rsp_valid);

  assert_view_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
    reg_addr == XL_OFS_VIEW |-> reg_rdata[30:XL_VP_IDX_W] == '0);

  assert_miss_kind_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> rsp_kind == '0);

  assert_accept_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_hit)
                                && $stable(rsp_kind));

  assert_stall_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |-> !req_ready);

endmodule

bind xlat_window_unit xlat_window_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_addr  (rsp_addr),
  .rsp_kind  (rsp_kind)
);

// File: tb/xlat_window_unit_test.sv
module xlat_window_unit_test;
  import xlat_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_inbound = 1'b0;
  logic [63:0] req_addr = '0;
  logic [2:0]  req_bar = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [63:0] rsp_addr;
  logic [2:0]  rsp_kind;

  always #2 clk = ~clk;

  xlat_window_unit uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_inbound(req_inbound), .req_addr(req_addr),
    .req_bar(req_bar), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind)
  );

  int vectors = 0;
  int errors  = 0;

  bit          q_hit [$];
  logic [63:0] q_addr[$];
  logic [2:0]  q_kind[$];
  string       q_tag [$];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  // Monitor: compares each consumed response against the scoreboard.
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (q_tag.size() == 0) begin
        check("R11 unexpected response", 64'd1, 64'd0);
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " hit"},  {63'd0, rsp_hit}, {63'd0, q_hit.pop_front()});
        check({t, " addr"}, rsp_addr, q_addr.pop_front());
        check({t, " kind"}, {61'd0, rsp_kind}, {61'd0, q_kind.pop_front()});
      end
    end
  end

  initial begin
    #(4 * 100000);
    check("watchdog expired", 64'd1, 64'd0);
    finish_run();
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(logic [11:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    check(tag, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic select(bit inb, int idx);
    wr(XL_OFS_VIEW, {inb, 27'd0, 4'(idx)});
  endtask

  task automatic prog(bit inb, int idx, logic [2:0] kind, logic [31:0] ctrl,
                      logic [63:0] base, logic [31:0] limit, logic [63:0] tgt);
    select(inb, idx);
    wr(XL_OFS_KIND, {29'd0, kind});
    wr(XL_OFS_CTRL, ctrl);
    wr(XL_OFS_BASE_LO, base[31:0]);
    wr(XL_OFS_BASE_HI, base[63:32]);
    wr(XL_OFS_LIMIT, limit);
    wr(XL_OFS_TGT_LO, tgt[31:0]);
    wr(XL_OFS_TGT_HI, tgt[63:32]);
  endtask

  // Driver: hands one request to the design and records what must come back.
  task automatic send(bit inb, logic [63:0] a, logic [2:0] bar, bit ehit,
                      logic [63:0] eaddr, logic [2:0] ekind, string tag);
    bit rdy;
    @(posedge clk); #1;
    req_valid = 1'b1; req_inbound = inb; req_addr = a; req_bar = bar;
    do begin
      @(negedge clk); rdy = req_ready;
      @(posedge clk);
    end while (!rdy);
    q_hit.push_back(ehit); q_addr.push_back(eaddr);
    q_kind.push_back(ekind); q_tag.push_back(tag);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && q_tag.size() != 0; i++) @(negedge clk);
    check("R11 scoreboard drained", 64'(q_tag.size()), 64'd0);
  endtask

  initial begin
    logic [63:0] held;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    check("R1 req_ready after reset", {63'd0, req_ready}, 64'd1);
    rd_check(XL_OFS_VIEW, 32'd0, "R1 selector after reset");
    rd_check(XL_OFS_CTRL, 32'd0, "R1 region control after reset");
    rd_check(XL_OFS_TGT_HI, 32'd0, "R1 region target after reset");

    // R2: selector fields
    wr(XL_OFS_VIEW, 32'hFFFF_FFFF);
    rd_check(XL_OFS_VIEW, 32'h8000_000F, "R2 selector keeps bit31 and 3:0");
    wr(XL_OFS_VIEW, 32'h8000_0003);
    rd_check(XL_OFS_VIEW, 32'h8000_0003, "R2 selector readback");

    // R5: kept bits of kind and control
    select(0, 0);
    wr(XL_OFS_KIND, 32'hFFFF_FFFD);
    rd_check(XL_OFS_KIND, 32'h0000_0005, "R5 kind bits 2:0");
    wr(XL_OFS_CTRL, 32'hFFFF_FFFF);
    rd_check(XL_OFS_CTRL, 32'hC000_0700, "R5 control kept bits");

    // Program the banks
    prog(0, 0, 3'd4, 32'h8000_0000, 64'h1_0000_0000, 32'h0000_0FFF, 64'h0100_0000);
    prog(0, 1, 3'd0, 32'h8000_0000, 64'h1_4000_0000, 32'h4FFF_FFFF, 64'h2_0000_0000);
    prog(0, 2, 3'd2, 32'hC000_0100, 64'h1_5000_0000, 32'h5000_FFFF, 64'h0000_1000);
    prog(0, 3, 3'd5, 32'h0000_0000, 64'h1_4000_0000, 32'h4000_0FFF, 64'h0200_0000);
    prog(1, 0, 3'd0, 32'hC000_0200, 64'h0, 32'h0, 64'h8000_0000);
    prog(1, 1, 3'd2, 32'h8000_0000, 64'hA000_0000, 32'hA000_FFFF, 64'h3_0000_0000);
    prog(1, 2, 3'd5, 32'hC000_0200, 64'h0, 32'h0, 64'hDEAD_0000);

    // R3: window follows the selector
    select(0, 1);
    rd_check(XL_OFS_LIMIT, 32'h4FFF_FFFF, "R3 outbound 1 limit");
    select(0, 0);
    rd_check(XL_OFS_LIMIT, 32'h0000_0FFF, "R3 outbound 0 limit untouched");
    rd_check(XL_OFS_BASE_HI, 32'h0000_0001, "R3 outbound 0 base high");
    rd_check(XL_OFS_KIND, 32'h0000_0004, "R3 outbound 0 kind");
    select(1, 1);
    rd_check(XL_OFS_TGT_HI, 32'h0000_0003, "R3 inbound 1 target high");

    // R4: out-of-range index
    select(0, 5);
    wr(XL_OFS_BASE_LO, 32'h0000_1234);
    rd_check(XL_OFS_BASE_LO, 32'd0, "R4 missing region reads zero");
    select(0, 1);
    rd_check(XL_OFS_BASE_LO, 32'h4000_0000, "R4 outbound 1 not written");
    select(1, 7);
    rd_check(XL_OFS_CTRL, 32'd0, "R4 missing inbound region reads zero");

    // R6: outbound range matching
    send(0, 64'h1_0000_0010, 3'd0, 1, 64'h0100_0010, 3'd4, "R6 cfg0 region");
    send(0, 64'h1_0000_0000, 3'd0, 1, 64'h0100_0000, 3'd4, "R6 base edge");
    send(0, 64'h1_0000_0FFF, 3'd0, 1, 64'h0100_0FFF, 3'd4, "R6 limit edge");
    send(0, 64'h1_4FFF_FFFF, 3'd0, 1, 64'h2_0FFF_FFFF, 3'd0, "R6 mem limit edge");
    send(0, 64'h1_5000_0004, 3'd1, 1, 64'h0000_1004, 3'd2, "R6 io with BAR mode bit");
    // R10: misses
    send(0, 64'h1_0000_1000, 3'd0, 0, 64'h1_0000_1000, 3'd0, "R10 past limit");
    send(0, 64'h1_3FFF_FFFF, 3'd0, 0, 64'h1_3FFF_FFFF, 3'd0, "R10 below base");
    send(0, 64'h2_4000_0000, 3'd0, 0, 64'h2_4000_0000, 3'd0, "R10 upper mismatch");
    send(0, 64'h1_4000_0010, 3'd0, 1, 64'h2_0000_0010, 3'd0, "R10 disabled region skipped");
    // R7 / R8 / R9 inbound
    send(1, 64'h40, 3'd2, 1, 64'h8000_0040, 3'd0, "R7 R9 BAR match lowest");
    send(1, 64'h40, 3'd1, 0, 64'h40, 3'd0, "R7 BAR mismatch");
    send(1, 64'hA000_0100, 3'd5, 1, 64'h3_0000_0100, 3'd2, "R8 inbound range");
    drain();

    // R9: overlapping outbound regions
    select(0, 3);
    wr(XL_OFS_CTRL, 32'h8000_0000);
    send(0, 64'h1_4000_0010, 3'd0, 1, 64'h2_0000_0010, 3'd0, "R9 lower index wins");
    drain();
    select(0, 1);
    wr(XL_OFS_CTRL, 32'h0);
    send(0, 64'h1_4000_0010, 3'd0, 1, 64'h0200_0010, 3'd5, "R9 next region after disable");
    drain();

    // R11: back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    send(0, 64'h1_0000_0020, 3'd0, 1, 64'h0100_0020, 3'd4, "R11 held response");
    @(posedge clk); #1;
    req_valid = 1'b1; req_inbound = 1'b0; req_addr = 64'h1_0000_0030;
    @(negedge clk);
    held = rsp_addr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 response held valid", {63'd0, rsp_valid}, 64'd1);
      check("R11 response held stable", rsp_addr, held);
      check("R11 request stalled", {63'd0, req_ready}, 64'd0);
    end
    q_hit.push_back(1); q_addr.push_back(64'h0100_0030);
    q_kind.push_back(3'd4); q_tag.push_back("R11 stalled request");
    @(posedge clk); #1 rsp_ready = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    drain();

    finish_run();
  end

endmodule